// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is the bus-facing controller of a small byte-wide nonvolatile-style memory reached over a two-wire serial bus. A front end outside the block filters the bus and hands it single-cycle event pulses: start, stop, clock rising edge and clock falling edge, along with the sampled data line. The block answers only through an open-drain pull enable. When that enable is high the data line is pulled low.

Every transfer opens with a select byte that carries a fixed device type, chip-enable or high-address bits, and a direction flag. A write-direction select is followed by a byte address, which loads the internal address counter. Data bytes that follow the address are stored one after another. A read-direction select returns bytes starting at the counter. A master builds a random read from a write select and an address byte with no data, then a repeated start and a read select. A write-lock input blocks stores without disturbing addressing or reads. The array capacity is a parameter from 128 to 2048 bytes. On the larger sizes, the low select bits carry memory address bits instead of being compared with the chip-enable pins.

Top module: `serial_eeprom_slave`

## Requirements
- R1: After reset `sda_pull` is 0, and every array location reads FFh before it is first written.
- R2: A select byte matches only when bits 7..4 equal 1010. For the default 512-byte size, bit 3 must equal `chip_en[2]`, bit 2 must equal `chip_en[1]`, and bit 1 is memory address bit 8, which is not compared with `chip_en[0]`. Bit 0 is the direction flag: 1 means read, 0 means write.
- R3: On a select match the block pulls the line low in the 9th clock of that byte. On a mismatch it never pulls the line and ignores every following clock until the next start.
- R4: After a write select, the address byte and each data byte are acknowledged. Each data byte is stored at the counter, and the counter then advances, so consecutive data bytes fill consecutive addresses.
- R5: While `wr_lock` is 1 at the last bit of a data byte, that byte gets no acknowledge and the array keeps its old content. Select and address bytes are still acknowledged, and the address byte still loads the counter.
- R6: A write select plus an address byte, followed by a repeated start and a read select, returns the byte at that address. The high address bits come from the write select.
- R7: A read select with no address phase returns the byte at the current counter, and the counter then advances by one.
- R8: While the master acknowledges, read bytes come from consecutive addresses. After the last address the next byte comes from address 0.
- R9: If the master leaves the line high in the 9th clock of a read byte, the block releases the line and drives nothing until the next start.
- R10: Read bits go out MSB first, with the pull enable set for a 0 bit. The enable changes only in the cycle after a falling-edge event, a start or a stop. It is released in the acknowledge clock of every read byte.
- R11: A stop releases the line at once and ends the transfer, even when a read bit is being driven.
- R12: Reads return the same data whatever the level of `wr_lock`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_start | input | 1 | One-cycle pulse: start or repeated start seen on the bus |
| bus_stop | input | 1 | One-cycle pulse: stop seen on the bus |
| scl_rise | input | 1 | One-cycle pulse: serial clock rising edge |
| scl_fall | input | 1 | One-cycle pulse: serial clock falling edge |
| sda_in | input | 1 | Sampled data line level, valid with `scl_rise` |
| chip_en | input | 3 | Chip-enable pin levels compared with select bits 3..1 |
| wr_lock | input | 1 | Write lock; 1 blocks storage of data bytes |
| sda_pull | output | 1 | Open-drain enable; 1 pulls the data line low |

## Verification
The bench targets the select bit that is an address bit at 512 bytes. It writes addresses 0 and 256 with different data. A decoder that compared that bit with a chip-enable pin would refuse one of the two writes, and one that dropped it would make both writes land on the same cell. Sequential reads across address 511 show whether the counter wraps to 0 or runs past the array. A locked write is checked for a refused data acknowledge and for unchanged content, which catches a lock that only hides the acknowledge. After a master refusal, and after a stop in the middle of a byte, the bench keeps clocking and watches for a slave that keeps driving stale bits.

// File: rtl/eep_pkg.sv
package eep_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEL,
    ST_ADDR,
    ST_WDATA,
    ST_RDATA
  } eep_state_e;

  // fixed device type carried in the top nibble of every select byte
  localparam logic [3:0] DEV_TYPE_CODE = 4'b1010;

  // bit-count values inside one nine-clock byte frame
  localparam logic [3:0] LAST_DATA_BIT = 4'd7;
  localparam logic [3:0] ACK_SLOT      = 4'd8;
  localparam logic [3:0] FRAME_DONE    = 4'd9;

endpackage

// File: rtl/eep_sel_decode.sv
module eep_sel_decode
  import eep_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic [7:0]      sel_byte,
  input  logic [2:0]      chip_en,
  output logic            hit,
  output logic            rd_req,
  output logic [HI_W-1:0] hi_addr
);
  localparam int HI_BITS = (ADDR_W > 8) ? ADDR_W - 8 : 0;
  localparam int HI_W    = (HI_BITS > 0) ? HI_BITS : 1;
  // select bits that carry address instead of a chip-enable compare
  localparam logic [2:0] ADDR_MASK = 3'((1 << HI_BITS) - 1);

  logic [2:0] pin_ok;

  assign pin_ok  = ADDR_MASK | ~(sel_byte[3:1] ^ chip_en);
  assign hit     = (sel_byte[7:4] == DEV_TYPE_CODE) && (&pin_ok);
  assign rd_req  = sel_byte[0];
  assign hi_addr = sel_byte[HI_W:1];

endmodule

// File: rtl/eep_mem_array.sv
module eep_mem_array #(
  parameter int DEPTH = 512,
  parameter int AW    = 9
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] cells [DEPTH];

  // erased state at power-up; kept out of reset so block RAM can be used
  initial begin
    for (int i = 0; i < DEPTH; i++) cells[i] = 8'hFF;
  end

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
    rdata <= cells[raddr];
  end

endmodule

// File: rtl/serial_eeprom_slave.sv
module serial_eeprom_slave
  import eep_pkg::*;
#(
  parameter int MEM_BYTES = 512
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bus_start,
  input  logic       bus_stop,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       sda_in,
  input  logic [2:0] chip_en,
  input  logic       wr_lock,
  output logic       sda_pull
);
  localparam int ADDR_W  = $clog2(MEM_BYTES);
  localparam int HI_BITS = (ADDR_W > 8) ? ADDR_W - 8 : 0;
  localparam int HI_W    = (HI_BITS > 0) ? HI_BITS : 1;
  localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

  eep_state_e        state, nxt_state;
  logic [3:0]        bit_cnt;
  logic [6:0]        rx_sh;
  logic [6:0]        tx_sh;
  logic              ack_pend;
  logic [ADDR_W-1:0] addr_ctr;
  logic [HI_W-1:0]   hi_pend;

  logic [7:0]        rx_full;
  logic              rx_state;
  logic              byte_done;
  logic              sel_hit, sel_rd;
  logic [HI_W-1:0]   sel_hi;
  logic [ADDR_W-1:0] load_addr;
  logic              mem_we;
  logic [7:0]        rd_q;

  assign rx_full   = {rx_sh, sda_in};
  assign rx_state  = (state == ST_SEL) || (state == ST_ADDR) || (state == ST_WDATA);
  assign byte_done = rx_state && scl_rise && (bit_cnt == LAST_DATA_BIT);
  assign mem_we    = byte_done && (state == ST_WDATA) && !wr_lock;

  eep_sel_decode #(.ADDR_W(ADDR_W)) u_sel (
    .sel_byte (rx_full),
    .chip_en  (chip_en),
    .hit      (sel_hit),
    .rd_req   (sel_rd),
    .hi_addr  (sel_hi)
  );

  // the counter load takes high bits from the select byte on large sizes
  generate
    if (HI_BITS > 0) begin : g_wide_addr
      assign load_addr = {hi_pend, rx_full};
    end else begin : g_narrow_addr
      assign load_addr = rx_full[ADDR_W-1:0];
    end
  endgenerate

  eep_mem_array #(.DEPTH(MEM_BYTES), .AW(ADDR_W)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .waddr (addr_ctr),
    .wdata (rx_full),
    .raddr (addr_ctr),
    .rdata (rd_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      nxt_state <= ST_IDLE;
      bit_cnt   <= '0;
      rx_sh     <= '0;
      tx_sh     <= '0;
      ack_pend  <= 1'b0;
      addr_ctr  <= '0;
      hi_pend   <= '0;
      sda_pull  <= 1'b0;
    end else if (bus_start) begin
      state    <= ST_SEL;
      bit_cnt  <= '0;
      ack_pend <= 1'b0;
      sda_pull <= 1'b0;
    end else if (bus_stop) begin
      state    <= ST_IDLE;
      bit_cnt  <= '0;
      sda_pull <= 1'b0;
    end else if (state != ST_IDLE) begin
      if (scl_rise) begin
        if (bit_cnt < FRAME_DONE) bit_cnt <= bit_cnt + 4'd1;
        if (rx_state && bit_cnt < ACK_SLOT) rx_sh <= rx_full[6:0];
        if (byte_done) begin
          case (state)
            ST_SEL: begin
              if (sel_hit) begin
                ack_pend  <= 1'b1;
                hi_pend   <= sel_hi;
                nxt_state <= sel_rd ? ST_RDATA : ST_ADDR;
              end else begin
                ack_pend  <= 1'b0;
                nxt_state <= ST_IDLE;
              end
            end
            ST_ADDR: begin
              addr_ctr  <= load_addr;
              ack_pend  <= 1'b1;
              nxt_state <= ST_WDATA;
            end
            default: begin
              if (!wr_lock) begin
                addr_ctr <= addr_ctr + ADDR_ONE;
                ack_pend <= 1'b1;
              end else begin
                ack_pend <= 1'b0;
              end
              nxt_state <= ST_WDATA;
            end
          endcase
        end
        // master acknowledge of a read byte: low keeps the stream going
        if (state == ST_RDATA && bit_cnt == ACK_SLOT)
          nxt_state <= sda_in ? ST_IDLE : ST_RDATA;
      end else if (scl_fall) begin
        if (bit_cnt == ACK_SLOT) begin
          sda_pull <= (state != ST_RDATA) && ack_pend;
        end else if (bit_cnt == FRAME_DONE) begin
          bit_cnt <= '0;
          state   <= nxt_state;
          if (nxt_state == ST_RDATA) begin
            tx_sh    <= rd_q[6:0];
            sda_pull <= ~rd_q[7];
            addr_ctr <= addr_ctr + ADDR_ONE;
          end else begin
            sda_pull <= 1'b0;
          end
        end else if (state == ST_RDATA && bit_cnt != 4'd0) begin
          sda_pull <= ~tx_sh[6];
          tx_sh    <= {tx_sh[5:0], 1'b0};
        end
      end
    end
  end

  // R10
  pull_after_fall_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_pull) |-> $past(scl_fall || bus_start || bus_stop));

  // R3
  rx_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_state && bit_cnt < ACK_SLOT) |-> !sda_pull);

  // R10
  rd_ack_release_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RDATA && bit_cnt == FRAME_DONE) |-> !sda_pull);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> !sda_pull);

  // R5
  locked_nack_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WDATA && scl_rise && bit_cnt == LAST_DATA_BIT && wr_lock)
      |=> !ack_pend);

endmodule

// File: tb/tb_serial_eeprom_slave.sv
`timescale 1ns/1ps
module tb_serial_eeprom_slave;

  localparam int NB = 512;
  localparam logic [2:0] CE = 3'b101;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_start = 1'b0, bus_stop = 1'b0, scl_rise = 1'b0, scl_fall = 1'b0;
  logic sda_in = 1'b1;
  logic wr_lock = 1'b0;
  logic sda_pull;

  int nchk = 0;
  int nerr = 0;
  logic [7:0] mdl [NB];
  int exp_ctr = 0;

  always #4 clk = ~clk;

  serial_eeprom_slave #(.MEM_BYTES(NB)) dut (
    .clk(clk), .rst(rst), .bus_start(bus_start), .bus_stop(bus_stop),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_in(sda_in),
    .chip_en(CE), .wr_lock(wr_lock), .sda_pull(sda_pull)
  );

  // {addr[8:0], data[7:0]} written by byte write then read back at random
  localparam logic [16:0] VEC [6] = '{
    {9'd0,   8'h3C}, {9'd511, 8'hA5}, {9'd256, 8'h00},
    {9'd255, 8'h81}, {9'd300, 8'h5A}, {9'd44,  8'hC3}
  };

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] selb(input logic [8:0] a, input logic rw);
    return {4'b1010, CE[2], CE[1], a[8], rw};
  endfunction

  task automatic clk_bit(input logic b, output logic mid);
    sda_in = b;
    repeat (2) @(negedge clk);
    scl_rise = 1'b1; @(negedge clk); scl_rise = 1'b0;
    @(negedge clk); mid = sda_pull;
    @(negedge clk);
    scl_fall = 1'b1; @(negedge clk); scl_fall = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic do_start();
    sda_in = 1'b1;
    bus_start = 1'b1; @(negedge clk); bus_start = 1'b0;
    @(negedge clk);
    scl_fall = 1'b1; @(negedge clk); scl_fall = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic do_stop();
    bus_stop = 1'b1; @(negedge clk); bus_stop = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    logic m;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], m);
    acked = sda_pull;
    clk_bit(1'b1, m);
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] v);
    logic pre, m;
    for (int i = 7; i >= 0; i--) begin
      pre  = sda_pull;
      v[i] = ~pre;
      clk_bit(1'b1, m);
      check("R10 bit stable while clock high", m, pre);
    end
    check("R10 read ack slot released", sda_pull, 1'b0);
    clk_bit(mack ? 1'b0 : 1'b1, m);
  endtask

  task automatic write_seq(input logic [8:0] a, input int n, input logic [7:0] base,
                           input logic lock);
    logic ak;
    do_start();
    send_byte(selb(a, 1'b0), ak);
    check("R3 write select ack", ak, 1'b1);
    send_byte(a[7:0], ak);
    check("R4 address ack", ak, 1'b1);
    wr_lock = lock;
    for (int i = 0; i < n; i++) begin
      logic [7:0] d = base ^ 8'(i * 8'h13);
      send_byte(d, ak);
      if (lock) check("R5 locked data nack", ak, 1'b0);
      else begin
        check("R4 data ack", ak, 1'b1);
        mdl[(int'(a) + i) % NB] = d;
      end
    end
    wr_lock = 1'b0;
    do_stop();
    exp_ctr = lock ? int'(a) : (int'(a) + n) % NB;
  endtask

  task automatic rand_read(input logic [8:0] a, input int n, input string req);
    logic ak;
    logic [7:0] v;
    do_start();
    send_byte(selb(a, 1'b0), ak);
    check("R3 dummy select ack", ak, 1'b1);
    send_byte(a[7:0], ak);
    check("R6 dummy address ack", ak, 1'b1);
    do_start();
    send_byte(selb(a, 1'b1), ak);
    check("R6 read select ack", ak, 1'b1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, v);
      check(req, v, mdl[(int'(a) + i) % NB]);
    end
    do_stop();
    exp_ctr = (int'(a) + n) % NB;
  endtask

  task automatic cur_read(input int n, input string req);
    logic ak;
    logic [7:0] v;
    do_start();
    send_byte(selb(9'd0, 1'b1), ak);
    check("R2 address bit not compared with pin", ak, 1'b1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, v);
      check(req, v, mdl[(exp_ctr + i) % NB]);
    end
    do_stop();
    exp_ctr = (exp_ctr + n) % NB;
  endtask

  initial begin
    logic ak, m;
    logic [7:0] v;
    for (int i = 0; i < NB; i++) mdl[i] = 8'hFF;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state and erased content
    check("R1 line released after reset", sda_pull, 1'b0);
    rand_read(9'd100, 1, "R1 erased byte reads FF");

    // R4 / R6: vector table of byte writes read back at random
    for (int k = 0; k < 6; k++) begin
      write_seq(VEC[k][16:8], 1, VEC[k][7:0], 1'b0);
      rand_read(VEC[k][16:8], 1, "R6 random read of written byte");
    end
    // address 0 and 256 differ only in select bit 1
    rand_read(9'd0, 1, "R2 high address bit from select");

    // R4 multi-byte write, R8 stream, R7 current address
    write_seq(9'd45, 5, 8'h11, 1'b0);
    rand_read(9'd45, 2, "R8 consecutive bytes");
    cur_read(2, "R7 current address read");

    // R5 lock keeps content
    write_seq(9'd44, 1, 8'h77, 1'b1);
    rand_read(9'd44, 1, "R5 locked byte unchanged");

    // R12 read with lock high
    wr_lock = 1'b1;
    rand_read(9'd300, 1, "R12 read under lock");
    wr_lock = 1'b0;

    // R8 wrap after the last address
    write_seq(9'd510, 1, 8'h6E, 1'b0);
    rand_read(9'd510, 3, "R8 wrap to address 0");
    cur_read(1, "R7 counter after wrap");

    // R9 master refusal then further clocks
    do_start();
    send_byte(selb(9'd0, 1'b1), ak);
    check("R3 read select ack", ak, 1'b1);
    recv_byte(1'b0, v);
    check("R7 byte before refusal", v, mdl[exp_ctr]);
    exp_ctr = (exp_ctr + 1) % NB;
    for (int i = 0; i < 9; i++) begin
      clk_bit(1'b0, m);
      check("R9 no drive after refusal", m | sda_pull, 1'b0);
    end
    do_stop();

    // R11 stop while a 0 bit is driven (address 256 holds 00)
    do_start();
    send_byte(selb(9'd256, 1'b0), ak);
    send_byte(8'h00, ak);
    do_start();
    send_byte(selb(9'd256, 1'b1), ak);
    check("R10 MSB 0 pulls line", sda_pull, 1'b1);
    do_stop();
    check("R11 stop releases line", sda_pull, 1'b0);
    exp_ctr = 257;
    cur_read(1, "R11 clean restart after stop");

    // R3 wrong device type, then ignored bytes
    do_start();
    send_byte(8'hB1, ak);
    check("R3 wrong type no ack", ak, 1'b0);
    send_byte(selb(9'd0, 1'b1), ak);
    check("R3 ignored until start", ak | sda_pull, 1'b0);
    do_stop();

    // R2 chip-enable mismatch on compared bit 3
    do_start();
    send_byte({4'b1010, ~CE[2], CE[1], 1'b0, 1'b1}, ak);
    check("R2 chip enable mismatch no ack", ak, 1'b0);
    do_stop();
    check("R2 line idle after mismatch", sda_pull, 1'b0);

    summary();
    $finish;
  end

endmodule